// File: doc/BRIEF.md
# Pixel to Bus Cycle Packer

This block sits between a pixel source and a narrow parallel display bus. Pixels arrive on a valid/ready stream. Each pixel is cut into bus words whose width matches the number of data lines, and each word goes out on a valid/ready bus-cycle stream. The pixel depth can be 12, 16, 18 or 24 bits and the bus can be 8, 9, 12 or 16 lines wide. The block supports whole ratios of bus cycles per pixel and also the fractional ratio in which two pixels share three bus cycles.

Software sets the depth, the bus width and the frame size (width times height, in pixels), then pulses `start`. The block latches the configuration and sets `busy`. It takes exactly the programmed number of pixels and emits every word they produce. After the last word it drops `busy` and pulses `frame_done`. If the pair of depth and width cannot be packed, `cfg_err` is raised and `start` is refused.

Top module: `pix_bus_packer`

## Requirements
- R1: After reset, `busy`, `pix_ready`, `word_valid` and `frame_done` are all low.
- R2: `cyc_fmt` reports the bus cycles per pixel for the live configuration as 0=1:1, 1=2:1, 2=3:1 and 3=3:2. Depth codes are 0=12, 1=16, 2=18 and 3=24 bits. Width codes are 0=8, 1=9, 2=12 and 3=16 lines. The legal pairs (depth/lines) are 12/12 and 16/16 (format 0), 16/8, 18/9 and 24/12 (format 1), 24/8 (format 2), and 12/8, 18/12 and 24/16 (format 3).
- R3: `cfg_err` is high for every pair of depth and width that R2 does not list, and low for the pairs it lists.
- R4: While `cfg_err` is high, `start` is refused: `busy` stays low and no pixel is accepted.
- R5: Only the low D bits of `pix_data` are used. The pixels form one bit stream, each pixel sent most significant bit first. The stream is cut into W-bit words in order, and each word sits in `word_data[W-1:0]` with the upper bits zero.
- R6: In the 3:2 format, two pixels give three words. The middle word holds the low half-word of the first pixel above the high half-word of the second.
- R7: In the 3:2 format with an odd pixel count, the last pixel's leftover bits form a final word whose unused low bits are zero.
- R8: While a word is offered and not taken, the word stays valid and unchanged, and `pix_ready` is low. No pixel is lost or repeated under backpressure.
- R9: Exactly `frame_len` pixels are accepted per frame, after which `pix_ready` stays low.
- R10: After the last word is taken, `frame_done` pulses for exactly one cycle and `busy` is low in that cycle.
- R11: Depth and width are latched at `start`; changing them during a frame does not alter that frame's words.
- R12: `start` is ignored while `busy` is high, including a new `frame_len`.
- R13: A frame of length zero produces no words and ends with a `frame_done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 2 | Pixel depth code |
| cfg_width | input | 2 | Bus width code |
| frame_len | input | CNT_W | Pixels per frame, latched at start |
| start | input | 1 | Start request (sets busy when legal) |
| busy | output | 1 | Frame in progress; clears itself at frame end |
| cfg_err | output | 1 | Live configuration cannot be packed |
| cyc_fmt | output | 2 | Live cycle format code |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel accepted this cycle when valid |
| pix_data | input | 24 | Pixel, right-justified |
| word_valid | output | 1 | Bus word offered |
| word_ready | input | 1 | Bus word taken this cycle when valid |
| word_data | output | 16 | Bus word, right-justified |
| frame_done | output | 1 | One-cycle pulse at frame end |

## Verification
Frames are run for every cycle format. Same-width pairs show that words are not reordered, and the 2:1 and 3:1 pairs show the most-significant-first split. The 3:2 pairs with even and odd pixel counts separate the shared middle word from the zero-padded trailing word. A random stall pattern on the word side, combined with gaps on the pixel side, checks that pixels are neither dropped nor repeated. A frame that rewrites the configuration and restarts midway shows that the latched settings hold, and a zero-length frame checks the immediate completion path.

// File: rtl/pix_bus_packer.sv
module pix_bus_packer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_depth,
  input  logic [1:0]       cfg_width,
  input  logic [CNT_W-1:0] frame_len,
  input  logic             start,
  output logic             busy,
  output logic             cfg_err,
  output logic [1:0]       cyc_fmt,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [23:0]      pix_data,
  output logic             word_valid,
  input  logic             word_ready,
  output logic [15:0]      word_data,
  output logic             frame_done
);

  localparam int PIX_W = 24;
  localparam int BUS_W = 16;
  localparam int ACC_W = 2 * PIX_W;
  localparam int NB_W  = $clog2(ACC_W + 1);

  logic [4:0]       dlen, wlen, d_q, w_q;
  logic [6:0]       d7, w7;
  logic             en;
  logic [CNT_W-1:0] rem;
  logic [ACC_W-1:0] acc, ins;
  logic [NB_W-1:0]  nbits;
  logic [PIX_W-1:0] pix_la;
  logic             push, pop, last_out;

  assign dlen = (cfg_depth == 2'd0) ? 5'd12 :
                (cfg_depth == 2'd1) ? 5'd16 :
                (cfg_depth == 2'd2) ? 5'd18 : 5'd24;
  assign wlen = (cfg_width == 2'd0) ? 5'd8  :
                (cfg_width == 2'd1) ? 5'd9  :
                (cfg_width == 2'd2) ? 5'd12 : 5'd16;
  assign d7 = {2'b00, dlen};
  assign w7 = {2'b00, wlen};

  always_comb begin
    cfg_err = 1'b0;
    cyc_fmt = 2'd0;
    if (d7 == w7)                cyc_fmt = 2'd0;
    else if (d7 == 7'd2 * w7)    cyc_fmt = 2'd1;
    else if (d7 == 7'd3 * w7)    cyc_fmt = 2'd2;
    else if (7'd2 * d7 == 7'd3 * w7) cyc_fmt = 2'd3;
    else                         cfg_err = 1'b1;
  end

  assign pix_la   = pix_data << (6'(PIX_W) - 6'(d_q));
  assign ins      = {pix_la, {PIX_W{1'b0}}} >> nbits;
  assign last_out = (rem == '0) && (nbits != '0);

  assign busy       = en;
  assign pix_ready  = en && (rem != '0) && (nbits < NB_W'(w_q));
  assign word_valid = en && ((nbits >= NB_W'(w_q)) || last_out);
  assign word_data  = BUS_W'(acc >> (7'(ACC_W) - 7'(w_q)));

  assign push = pix_valid && pix_ready;
  assign pop  = word_valid && word_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en         <= 1'b0;
      rem        <= '0;
      acc        <= '0;
      nbits      <= '0;
      d_q        <= 5'd16;
      w_q        <= 5'd16;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!en) begin
        if (start && !cfg_err) begin
          en    <= 1'b1;
          rem   <= frame_len;
          acc   <= '0;
          nbits <= '0;
          d_q   <= dlen;
          w_q   <= wlen;
        end
      end else if ((rem == '0) && (nbits == '0)) begin
        en         <= 1'b0;
        frame_done <= 1'b1;
      end else if (push) begin
        acc   <= acc | ins;
        nbits <= nbits + NB_W'(d_q);
        rem   <= rem - CNT_W'(1);
      end else if (pop) begin
        acc   <= acc << w_q;
        nbits <= (nbits >= NB_W'(w_q)) ? nbits - NB_W'(w_q) : '0;
      end
    end
  end

endmodule

module pix_bus_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        cfg_err,
  input logic        pix_ready,
  input logic        word_valid,
  input logic        word_ready,
  input logic [15:0] word_data,
  input logic        frame_done
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pix_ready && !word_valid);

  // R4
  refuse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && cfg_err |=> !busy);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |=> word_valid && $stable(word_data));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |-> !pix_ready);

  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy && $past(busy));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

bind pix_bus_packer pix_bus_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cfg_err(cfg_err),
  .pix_ready(pix_ready), .word_valid(word_valid), .word_ready(word_ready),
  .word_data(word_data), .frame_done(frame_done)
);

// File: tb/pix_bus_packer_bench.sv
`timescale 1ns/1ps
module pix_bus_packer_bench;
  localparam int CNT_W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_depth = 2'd1, cfg_width = 2'd3;
  logic [CNT_W-1:0] frame_len = '0;
  logic start = 1'b0;
  logic busy, cfg_err, pix_ready, word_valid, frame_done;
  logic [1:0] cyc_fmt;
  logic pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic word_ready = 1'b1;
  logic [15:0] word_data;

  pix_bus_packer #(.CNT_W(CNT_W)) u_pix_bus_packer (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_width(cfg_width),
    .frame_len(frame_len), .start(start), .busy(busy), .cfg_err(cfg_err),
    .cyc_fmt(cyc_fmt), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .frame_done(frame_done)
  );

  always #2 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0, pix_acc = 0, fd_cnt = 0;
  logic [15:0] expq[$];
  string tag = "R5";
  bit bp = 1'b0;
  bit prev_stall = 1'b0, prev_fd = 1'b0;
  logic [15:0] prev_word = '0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(bit ok, string r, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  function automatic int dval(logic [1:0] c);
    case (c) 2'd0: return 12; 2'd1: return 16; 2'd2: return 18; default: return 24; endcase
  endfunction
  function automatic int wval(logic [1:0] c);
    case (c) 2'd0: return 8; 2'd1: return 9; 2'd2: return 12; default: return 16; endcase
  endfunction
  function automatic int fmt_exp(int d, int w);
    if ((d == 12 && w == 12) || (d == 16 && w == 16)) return 0;
    if ((d == 16 && w == 8) || (d == 18 && w == 9) || (d == 24 && w == 12)) return 1;
    if (d == 24 && w == 8) return 2;
    if ((d == 12 && w == 8) || (d == 18 && w == 12) || (d == 24 && w == 16)) return 3;
    return -1;
  endfunction
  function automatic logic [23:0] pixval(int seed, int p);
    return 24'((p * 40503 + seed * 7919 + 24'h5A3C1) ^ (p << 11));
  endfunction

  always begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    word_ready = bp ? (lfsr[0] & lfsr[2]) | lfsr[5] : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(word_valid && word_data == prev_word, "R8", "held word", int'(word_data), int'(prev_word));
      end
      if (word_valid && !word_ready) chk(!pix_ready, "R8", "pix_ready in stall", int'(pix_ready), 0);
      if (word_valid && word_ready) begin
        if (expq.size() == 0) chk(1'b0, tag, "unexpected word", int'(word_data), 0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          chk(word_data == e, tag, "word", int'(word_data), int'(e));
        end
      end
      if (pix_valid && pix_ready) pix_acc++;
      if (frame_done) begin
        fd_cnt++;
        chk(!busy, "R10", "busy at done", int'(busy), 0);
        chk(!prev_fd, "R10", "done width", int'(prev_fd), 0);
      end
      prev_stall = word_valid && !word_ready;
      prev_word  = word_data;
      prev_fd    = frame_done;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_frame(logic [1:0] dc, logic [1:0] wc, int npix, int seed,
                           bit gap, bit disturb, string r);
    int d, w, total, nw, f0;
    d = dval(dc); w = wval(wc); total = npix * d; nw = (total + w - 1) / w;
    tag = r;
    for (int k = 0; k < nw; k++) begin
      logic [15:0] ew;
      ew = '0;
      for (int j = 0; j < w; j++) begin
        int i;
        i = k * w + j;
        if (i < total) begin
          logic [23:0] pv;
          pv = pixval(seed, i / d);
          ew[w-1-j] = pv[d-1-(i%d)];
        end
      end
      expq.push_back(ew);
    end
    cfg_depth = dc; cfg_width = wc; frame_len = CNT_W'(npix);
    pix_acc = 0; f0 = fd_cnt;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int n = 0; n < npix; n++) begin
      if (gap && (n % 3 == 1)) begin pix_valid = 1'b0; @(posedge clk); #1; end
      if (disturb && n == 2) begin
        start = 1'b1; cfg_depth = cfg_depth ^ 2'd1; frame_len = CNT_W'(npix + 3);
      end
      pix_valid = 1'b1;
      pix_data = pixval(seed, n);
      do @(negedge clk); while (!pix_ready);
      @(posedge clk); #1;
      start = 1'b0;
    end
    pix_valid = 1'b0;
    @(negedge clk);
    chk(!pix_ready, "R9", "pix_ready after last pixel", int'(pix_ready), 0);
    while (fd_cnt == f0) @(negedge clk);
    chk(expq.size() == 0, r, "words left", expq.size(), 0);
    chk(pix_acc == npix, "R9", "pixels accepted", pix_acc, npix);
    chk(!busy, "R10", "busy after frame", int'(busy), 0);
    expq.delete();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(!busy && !pix_ready && !word_valid && !frame_done, "R1", "reset outputs",
        int'({busy, pix_ready, word_valid, frame_done}), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int dc = 0; dc < 4; dc++) begin
      for (int wc = 0; wc < 4; wc++) begin
        int fe;
        cfg_depth = 2'(dc); cfg_width = 2'(wc);
        #1;
        fe = fmt_exp(dval(2'(dc)), wval(2'(wc)));
        if (fe < 0) chk(cfg_err, "R3", "cfg_err set", int'(cfg_err), 1);
        else begin
          chk(!cfg_err, "R3", "cfg_err clear", int'(cfg_err), 0);
          chk(int'(cyc_fmt) == fe, "R2", "cyc_fmt", int'(cyc_fmt), fe);
        end
      end
    end

    @(posedge clk); #1;
    cfg_depth = 2'd1; cfg_width = 2'd2; frame_len = CNT_W'(4);
    pix_valid = 1'b1; pix_data = 24'h123456;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!busy && !pix_ready, "R4", "refused start", int'({busy, pix_ready}), 0);
    @(posedge clk); #1;
    pix_valid = 1'b0;

    run_frame(2'd1, 2'd3, 6, 1, 1'b0, 1'b0, "R5");
    run_frame(2'd1, 2'd0, 5, 2, 1'b0, 1'b0, "R5");
    run_frame(2'd3, 2'd0, 4, 3, 1'b1, 1'b0, "R5");
    run_frame(2'd0, 2'd0, 6, 4, 1'b0, 1'b0, "R6");
    bp = 1'b1;
    run_frame(2'd3, 2'd3, 5, 5, 1'b1, 1'b0, "R7");
    run_frame(2'd2, 2'd1, 7, 6, 1'b1, 1'b0, "R8");
    run_frame(2'd2, 2'd2, 3, 7, 1'b0, 1'b0, "R7");
    bp = 1'b0;
    run_frame(2'd3, 2'd2, 6, 8, 1'b0, 1'b0, "R5");
    run_frame(2'd1, 2'd0, 8, 9, 1'b1, 1'b1, "R11");
    run_frame(2'd0, 2'd2, 0, 10, 1'b0, 1'b0, "R13");
    run_frame(2'd3, 2'd3, 4, 11, 1'b0, 1'b1, "R12");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule